// File: doc/BRIEF.md
# Consumer Channel-Status Bit Sequencer

This block feeds the channel-status (C) bit of an S/PDIF transmitter. A status block lasts 192 frames, and each subframe of each frame carries one status bit. The block keeps a frame counter that moves forward on a frame-advance strobe. For the current frame it presents the C bit for subframe A and the C bit for subframe B, together with a block-start flag that is high during frame 0 of every block.

Only consumer-format status is generated. The first 40 bits of the block are assembled from configuration inputs: a non-PCM flag, an 8-bit category code, a 4-bit source number, a word-length indication, and a separate 4-bit channel number for each subframe. Every other bit of the block is zero.

The configuration is captured once per block, on the advance that enters frame 0. Changes to the configuration inputs in the middle of a block therefore never produce a block that mixes old and new settings. After reset the counter sits on the last frame of an idle block, so the first advance opens a fresh block.

Top module: `chstat_sequencer`

## Requirements
- R1: After reset, and before the first frame advance, blockStart, cBitA and cBitB are all 0.
- R2: Each frameAdv pulse moves the frame position forward by one and wraps from frame 191 to frame 0. The first advance after reset enters frame 0. blockStart is 1 exactly during frame 0.
- R3: Status bit 0 (frame 0) is always 0, which marks the consumer format. Bit 1 equals nonPcm.
- R4: Bits 8..15 carry category[0..7], with bit 8 = category[0]. Bits 16..19 carry sourceNum[0..3], with bit 16 = sourceNum[0].
- R5: Bits 20..23 carry the channel number, LSB at bit 20. Subframe A uses chanNumA and subframe B uses chanNumB. Outside bits 20..23, cBitA equals cBitB.
- R6: Bit 32 equals maxLen24, where 1 means a 24-bit maximum and 0 means 20 bits. Bits 33..35 carry wordLenCode[0..2], with bit 33 = wordLenCode[0].
- R7: Bits 2..7, 24..31 and 36..191 are 0 in both subframes.
- R8: The configuration is sampled on the advance that enters frame 0. Changes to the inputs during frames 1..191 have no effect on the rest of that block.
- R9: While frameAdv is low, blockStart, cBitA and cBitB hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameAdv | input | 1 | One-cycle strobe: move to the next frame |
| nonPcm | input | 1 | 1 when the payload is not linear PCM audio |
| category | input | 8 | Category code |
| sourceNum | input | 4 | Source number |
| chanNumA | input | 4 | Channel number sent in subframe A |
| chanNumB | input | 4 | Channel number sent in subframe B |
| maxLen24 | input | 1 | Maximum word length flag (1 = 24 bits, 0 = 20 bits) |
| wordLenCode | input | 3 | Sample word length code (0 = not indicated) |
| blockStart | output | 1 | High during frame 0 of a block |
| cBitA | output | 1 | Channel-status bit for subframe A of the current frame |
| cBitB | output | 1 | Channel-status bit for subframe B of the current frame |

## Verification
Each full block is checked frame by frame against a status word that the bench builds from the configuration fields. The configurations used are all zeros, all ones, two alternating patterns, and a walking one across every configuration bit. The walking one shows that each field lands at its own bit positions with the LSB first, and that the two channel fields stay separate. The all-ones and alternating patterns catch bits that are swapped or merged between fields, and they confirm that the reserved ranges stay zero. In every block the inputs are inverted after frame 3, so any early capture of the configuration shows up as a miscompare. Idle stretches with no advance confirm that the outputs hold steady.

// File: rtl/chstat_pkg.sv
package chstat_pkg;

  // Width of the status field that carries data; its layout is fixed.
  localparam int STATUS_BITS = 40;
  localparam int SEL_W       = $clog2(STATUS_BITS);

  typedef struct packed {
    logic       nonPcm;
    logic [7:0] category;
    logic [3:0] sourceNum;
    logic [3:0] chanNumA;
    logic [3:0] chanNumB;
    logic       maxLen24;
    logic [2:0] wordLenCode;
  } csConfig_t;

  // Strobes from the sequencing control to the status datapath.
  typedef struct packed {
    logic             loadCfg;
    logic             inWindow;
    logic [SEL_W-1:0] bitSel;
  } seqStrobes_t;

endpackage

// File: rtl/chstat_ctrl.sv
module chstat_ctrl
  import chstat_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameAdv,
  output seqStrobes_t strb,
  output logic        blockStart
);

  localparam int FRAME_W = $clog2(BLOCK_FRAMES);
  localparam logic [FRAME_W-1:0] LAST_FRAME = FRAME_W'(BLOCK_FRAMES - 1);
  localparam logic [FRAME_W-1:0] WIN_END    = FRAME_W'(STATUS_BITS);

  logic [FRAME_W-1:0] frameIdx;

  // Reset parks the counter on the last frame so that the first advance opens a block.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frameIdx <= LAST_FRAME;
    end else if (frameAdv) begin
      frameIdx <= (frameIdx == LAST_FRAME) ? '0 : frameIdx + FRAME_W'(1);
    end
  end

  always_comb begin
    strb.loadCfg  = frameAdv && (frameIdx == LAST_FRAME);
    strb.inWindow = rstN && (frameIdx < WIN_END);
    strb.bitSel   = SEL_W'(frameIdx);
    blockStart    = rstN && (frameIdx == '0);
  end

endmodule

// File: rtl/chstat_datapath.sv
module chstat_datapath
  import chstat_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  csConfig_t   cfgIn,
  input  seqStrobes_t strb,
  output logic        cBitA,
  output logic        cBitB
);

  localparam int PAD_W = 2 ** SEL_W;

  csConfig_t shadow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadow <= '0;
    end else if (strb.loadCfg) begin
      shadow <= cfgIn;
    end
  end

  function automatic logic [STATUS_BITS-1:0] buildWord(csConfig_t c, logic [3:0] chan);
    logic [STATUS_BITS-1:0] w;
    w        = '0;
    w[1]     = c.nonPcm;
    w[15:8]  = c.category;
    w[19:16] = c.sourceNum;
    w[23:20] = chan;
    w[32]    = c.maxLen24;
    w[35:33] = c.wordLenCode;
    return w;
  endfunction

  logic [PAD_W-1:0] wordA;
  logic [PAD_W-1:0] wordB;

  always_comb begin
    wordA = PAD_W'(buildWord(shadow, shadow.chanNumA));
    wordB = PAD_W'(buildWord(shadow, shadow.chanNumB));
    cBitA = strb.inWindow & wordA[strb.bitSel];
    cBitB = strb.inWindow & wordB[strb.bitSel];
  end

endmodule

// File: rtl/chstat_sequencer.sv
module chstat_sequencer
  import chstat_pkg::*;
#(
  parameter int BLOCK_FRAMES = 192
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameAdv,
  input  logic       nonPcm,
  input  logic [7:0] category,
  input  logic [3:0] sourceNum,
  input  logic [3:0] chanNumA,
  input  logic [3:0] chanNumB,
  input  logic       maxLen24,
  input  logic [2:0] wordLenCode,
  output logic       blockStart,
  output logic       cBitA,
  output logic       cBitB
);

  csConfig_t   cfgLive;
  seqStrobes_t strb;

  always_comb begin
    cfgLive.nonPcm      = nonPcm;
    cfgLive.category    = category;
    cfgLive.sourceNum   = sourceNum;
    cfgLive.chanNumA    = chanNumA;
    cfgLive.chanNumB    = chanNumB;
    cfgLive.maxLen24    = maxLen24;
    cfgLive.wordLenCode = wordLenCode;
  end

  chstat_ctrl #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameAdv(frameAdv), .strb(strb), .blockStart(blockStart)
  );

  chstat_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfgIn(cfgLive), .strb(strb), .cBitA(cBitA), .cBitB(cBitB)
  );

endmodule

// File: rtl/chstat_checker.sv
module chstat_checker #(
  parameter int BLOCK_FRAMES = 192
) (
  input logic clk,
  input logic rstN,
  input logic frameAdv,
  input logic blockStart,
  input logic cBitA,
  input logic cBitB
);

  localparam int FRAME_W = $clog2(BLOCK_FRAMES);
  localparam logic [FRAME_W-1:0] LAST_POS = FRAME_W'(BLOCK_FRAMES - 1);

  // Independent position tracker driven only by the strobe input.
  logic [FRAME_W-1:0] pos;
  always_ff @(posedge clk) begin
    if (!rstN) pos <= LAST_POS;
    else if (frameAdv) pos <= (pos == LAST_POS) ? '0 : pos + FRAME_W'(1);
  end

  // R2
  start_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockStart == (pos == '0));

  // R3
  bit0_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockStart |-> (!cBitA && !cBitB));

  // R7
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pos >= FRAME_W'(40)) |-> (!cBitA && !cBitB));

  // R5
  sub_match_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pos < FRAME_W'(20) || pos > FRAME_W'(23)) |-> (cBitA == cBitB));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameAdv |=> ($stable(blockStart) && $stable(cBitA) && $stable(cBitB)));

endmodule

bind chstat_sequencer chstat_checker #(.BLOCK_FRAMES(BLOCK_FRAMES)) u_chk (
  .clk(clk), .rstN(rstN), .frameAdv(frameAdv),
  .blockStart(blockStart), .cBitA(cBitA), .cBitB(cBitB)
);

// File: tb/tb_chstat_sequencer.sv
module tb_chstat_sequencer;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic frameAdv = 1'b0;
  logic [24:0] live = '0;
  logic blockStart, cBitA, cBitB;
  int vectors = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chstat_sequencer dut (
    .clk(clk), .rstN(rstN), .frameAdv(frameAdv),
    .nonPcm(live[24]), .category(live[23:16]), .sourceNum(live[15:12]),
    .chanNumA(live[11:8]), .chanNumB(live[7:4]),
    .maxLen24(live[3]), .wordLenCode(live[2:0]),
    .blockStart(blockStart), .cBitA(cBitA), .cBitB(cBitB)
  );

  function automatic logic expBit(logic [24:0] p, int idx, bit subB);
    logic [3:0] ch;
    ch = subB ? p[7:4] : p[11:8];
    if (idx == 1) return p[24];
    if (idx >= 8 && idx <= 15) return p[16 + idx - 8];
    if (idx >= 16 && idx <= 19) return p[12 + idx - 16];
    if (idx >= 20 && idx <= 23) return ch[idx - 20];
    if (idx == 32) return p[3];
    if (idx >= 33 && idx <= 35) return p[idx - 33];
    return 1'b0;
  endfunction

  function automatic string reqOf(int idx);
    if (idx <= 1) return "R3";
    if (idx >= 8 && idx <= 19) return "R4";
    if (idx >= 20 && idx <= 23) return "R5";
    if (idx >= 32 && idx <= 35) return "R6";
    return "R7";
  endfunction

  task automatic check(string req, logic act, logic exp, int frame);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s frame %0d: actual %b expected %b", req, frame, act, exp);
    end
  endtask

  task automatic advance();
    @(negedge clk) frameAdv = 1'b1;
    @(negedge clk) frameAdv = 1'b0;
  endtask

  task automatic checkFrame(logic [24:0] held, int f, string tagOverride);
    string tg;
    tg = (tagOverride != "") ? tagOverride : reqOf(f);
    check("R2", blockStart, (f == 0), f);
    check(tg, cBitA, expBit(held, f, 1'b0), f);
    check(tg, cBitB, expBit(held, f, 1'b1), f);
  endtask

  task automatic runBlock(logic [24:0] cfg);
    live = cfg;
    for (int f = 0; f < 192; f++) begin
      advance();
      checkFrame(cfg, f, "");
      // R8: scramble live inputs mid-block; held status must not change
      if (f == 3) begin
        live = ~cfg;
        @(negedge clk);
        checkFrame(cfg, f, "R8");
      end
      // R9: idle cycles without an advance
      if (f % 50 == 7) begin
        repeat (3) @(negedge clk);
        checkFrame(cfg, f, "R9");
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", blockStart, 1'b0, -1);
    check("R1", cBitA, 1'b0, -1);
    check("R1", cBitB, 1'b0, -1);
    runBlock(25'h0000000);
    runBlock(25'h1FFFFFF);
    runBlock(25'h0AAAAAA);
    runBlock(25'h1555555);
    for (int k = 0; k < 25; k++) runBlock(25'(1) << k);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

endmodule